// File: doc/BRIEF.md
# Terminal-Count Down-Counter Channel

This block is a single down-counter channel with two behaviours chosen by a mode input. In interrupt mode, the output line is held low while a freshly written count runs down. It rises when the count reaches zero and stays up until software writes again. In strobe mode, the output idles high and drops for exactly one clock once the count reaches zero. After that the output stays high while the counter keeps wrapping.

Software supplies the count through a byte-wide write port. A two-byte flag selects between a single-byte count and a count sent as a low byte followed by a high byte. A level-sensitive gate input pauses the decrement and never acts on the output. The current count is always visible on a readback port. Any change of the mode input re-initialises the channel, as a mode-set would.

Top module: `tcnt_timer`

## Requirements
- R1: After synchronous reset the count reads 0 and OUT sits at the idle level of the selected mode (low when mode_i=0 interrupt, high when mode_i=1 strobe); the count does not move until a count has been loaded.
- R2: A completed write is copied into the counter on the clock edge after the one that accepted the write. A single-byte write (two_byte_i=0) places the byte in bits 7:0 when wr_hi_i=0 and in bits 15:8 when wr_hi_i=1; the other byte is zero.
- R3: With gate_i high the loaded count drops by one on every clock; with gate_i low it holds. The gate never changes OUT in either mode.
- R4: In interrupt mode any accepted write drives OUT low on that edge. OUT rises on the edge where the count reaches 0, N enabled clocks after the load of N, and stays high while the count wraps to 0xFFFF.
- R5: In strobe mode OUT is low only during the single clock in which the count reads 0 after the load, then returns high and stays high while the counter wraps, until a new count is loaded.
- R6: A loaded value of 0 means 65536: the zero count is reached after 65536 enabled decrements.
- R7: In interrupt mode with two_byte_i=1, a low-byte write (wr_hi_i=0) freezes the count from the next edge. The following high-byte write loads {high,low} on the next edge, and counting resumes.
- R8: In strobe mode with two_byte_i=1, the low-byte write leaves counting running. The high-byte write loads {high,low} on the next edge.
- R9: A change of mode_i re-initialises the channel at the next edge. OUT goes to the new mode's idle level, the count holds its value without decrementing, and a pending load is dropped until a new count is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| gate_i | input | 1 | Count enable level |
| mode_i | input | 1 | 0 = interrupt on zero count, 1 = one-clock strobe |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte being written |
| wr_hi_i | input | 1 | 0 = low byte, 1 = high byte |
| two_byte_i | input | 1 | 1 = count is sent as low then high byte |
| out_o | output | 1 | Timer output line |
| count_o | output | 16 | Current counter value |

## Verification
Errors in the count register show on count_o in the very next cycle. Errors in the armed or valid flags surface later, either as a missing edge on OUT or as an extra one when the count next passes zero. That can be up to 65536 enabled clocks later, which is why the zero-count case is run in full. A stuck halt or pending-load flag shows as a count that freezes, or reloads, one cycle away from the expected value. The sweeps sample count_o and OUT every cycle over short counts in both modes.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
    typedef enum logic {
        MODE_IRQ    = 1'b0,
        MODE_STROBE = 1'b1
    } tmode_e;
endpackage

// File: rtl/tcnt_byte_asm.sv
module tcnt_byte_asm
    import tcnt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  tmode_e                mode_i,
    input  logic                  wr_en_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    input  logic                  wr_hi_i,
    input  logic                  two_byte_i,
    output logic                  load_o,
    output logic [2*BYTE_W-1:0]   value_o,
    output logic                  halt_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic              halt;
    } asm_t;

    asm_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        load_o  = wr_en_i && (!two_byte_i || wr_hi_i);
        if (two_byte_i) begin
            value_o = {wr_data_i, st_q.lo};
        end else if (wr_hi_i) begin
            value_o = {wr_data_i, {BYTE_W{1'b0}}};
        end else begin
            value_o = {{BYTE_W{1'b0}}, wr_data_i};
        end
        if (wr_en_i && two_byte_i && !wr_hi_i) begin
            st_d.lo   = wr_data_i;
            st_d.halt = (mode_i == MODE_IRQ);
        end
        if (load_o || mode_i == MODE_STROBE) begin
            st_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{lo: '0, halt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o = st_q.halt;

    // R8
    strobe_no_halt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == MODE_STROBE) |=> !halt_o);

    logic unused_w;
    assign unused_w = (CNT_W == 0);
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  tmode_e            mode_i,
    input  logic              gate_i,
    input  logic              wr_any_i,
    input  logic              load_req_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic              halt_i,
    output logic              out_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cr;
        logic             pend;
        logic             valid;
        logic             armed;
        logic             out;
        tmode_e           mode;
    } core_t;

    core_t st_q, st_d;
    logic  reinit, dec_en, tc_hit;

    always_comb begin
        st_d   = st_q;
        reinit = (mode_i != st_q.mode);
        dec_en = st_q.valid && gate_i && !halt_i && !st_q.pend;
        tc_hit = dec_en && st_q.armed && (st_q.cnt == CNT_ONE);

        if (dec_en) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
        end
        if (st_q.mode == MODE_STROBE) begin
            st_d.out = !tc_hit;
        end else if (tc_hit) begin
            st_d.out = 1'b1;
        end
        if (tc_hit) begin
            st_d.armed = 1'b0;
        end
        if (st_q.pend) begin
            st_d.cnt   = st_q.cr;
            st_d.valid = 1'b1;
            st_d.armed = 1'b1;
            st_d.pend  = 1'b0;
        end
        if (wr_any_i && st_q.mode == MODE_IRQ) begin
            st_d.out = 1'b0;
        end
        if (load_req_i) begin
            st_d.cr   = load_val_i;
            st_d.pend = 1'b1;
        end
        if (reinit) begin
            st_d.mode  = mode_i;
            st_d.cnt   = st_q.cnt;
            st_d.valid = 1'b0;
            st_d.armed = 1'b0;
            st_d.pend  = 1'b0;
            st_d.out   = (mode_i == MODE_STROBE);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{cnt: '0, cr: '0, pend: 1'b0, valid: 1'b0, armed: 1'b0,
                      out: (mode_i == MODE_STROBE), mode: mode_i};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o   = st_q.out;
    assign count_o = st_q.cnt;

    // R3
    gate_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gate_i && !st_q.pend) |=> $stable(st_q.cnt));

    // R7
    halt_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_i && !st_q.pend) |=> $stable(st_q.cnt));

    // R2
    load_copy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.pend && mode_i == st_q.mode) |=> (st_q.cnt == $past(st_q.cr)));

    // R4
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(st_q.out) && st_q.mode == MODE_IRQ) |-> (st_q.cnt == '0));

    // R5
    strobe_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.mode == MODE_STROBE && mode_i == MODE_STROBE && !st_q.out) |=> st_q.out);
endmodule

// File: rtl/tcnt_timer.sv
module tcnt_timer
    import tcnt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              gate_i,
    input  logic              mode_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              wr_hi_i,
    input  logic              two_byte_i,
    output logic              out_o,
    output logic [CNT_W-1:0]  count_o
);
    tmode_e           mode_sel;
    logic             load_req;
    logic [CNT_W-1:0] load_val;
    logic             halt;

    assign mode_sel = tmode_e'(mode_i);

    tcnt_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode_sel),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .wr_hi_i    (wr_hi_i),
        .two_byte_i (two_byte_i),
        .load_o     (load_req),
        .value_o    (load_val),
        .halt_o     (halt)
    );

    tcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode_sel),
        .gate_i     (gate_i),
        .wr_any_i   (wr_en_i),
        .load_req_i (load_req),
        .load_val_i (load_val),
        .halt_i     (halt),
        .out_o      (out_o),
        .count_o    (count_o)
    );
endmodule

// File: tb/tcnt_timer_test.sv
module tcnt_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate = 1'b0;
    logic        mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_hi = 1'b0;
    logic        two_byte = 1'b0;
    logic        out;
    logic [15:0] count;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tcnt_timer uut (
        .clk_i(clk), .rst_i(rst), .gate_i(gate), .mode_i(mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_hi_i(wr_hi),
        .two_byte_i(two_byte), .out_o(out), .count_o(count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; mode = m; gate = 1'b0; wr_en = 1'b0; two_byte = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, input logic hi);
        wr_en = 1'b1; wr_data = b; wr_hi = hi;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1 reset state, interrupt mode, no counting before a load
        do_reset(1'b0);
        check("R1 out", int'(out), 0);
        check("R1 count", int'(count), 0);
        gate = 1'b1;
        tick(); tick(); tick();
        check("R1 idle count", int'(count), 0);
        check("R1 idle out", int'(out), 0);
        do_reset(1'b1);
        check("R1 strobe out", int'(out), 1);
        check("R1 strobe count", int'(count), 0);

        // R2 R3 R4 R5 sweep of short counts in both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 1; n <= 12; n++) begin
                do_reset(m[0]);
                gate = 1'b1;
                wr(8'(n), 1'b0);
                check(m ? "R5 run out" : "R4 write out", int'(out), m);
                tick();
                check("R2 load", int'(count), n);
                for (int i = 1; i < n; i++) begin
                    tick();
                    check("R3 decrement", int'(count), n - i);
                    check(m ? "R5 high" : "R4 low", int'(out), m);
                end
                tick();
                check("R3 zero", int'(count), 0);
                check(m ? "R5 strobe" : "R4 rise", int'(out), m ? 0 : 1);
                tick();
                check("R3 wrap", int'(count), 16'hFFFF);
                check(m ? "R5 end" : "R4 hold", int'(out), 1);
                tick(); tick();
                check(m ? "R5 once" : "R4 stay", int'(out), 1);
            end
        end

        // R2 single byte into high half
        do_reset(1'b0);
        wr(8'h02, 1'b1);
        tick();
        check("R2 high byte", int'(count), 16'h0200);

        // R3 gate pauses, interrupt mode
        do_reset(1'b0);
        gate = 1'b1;
        wr(8'd5, 1'b0);
        tick();
        gate = 1'b0;
        tick(); tick(); tick();
        check("R3 frozen", int'(count), 5);
        check("R3 out", int'(out), 0);
        gate = 1'b1;
        tick();
        check("R3 resume", int'(count), 4);
        tick(); tick(); tick(); tick();
        check("R4 reach", int'(out), 1);
        gate = 1'b0;
        tick(); tick();
        check("R3 gate no effect irq", int'(out), 1);

        // R3 gate low during the strobe
        do_reset(1'b1);
        gate = 1'b1;
        wr(8'd3, 1'b0);
        tick(); tick(); tick(); tick();
        check("R5 low", int'(out), 0);
        gate = 1'b0;
        tick();
        check("R3 gate no effect strobe", int'(out), 1);
        check("R3 held zero", int'(count), 0);

        // R6 zero count is 65536
        do_reset(1'b0);
        gate = 1'b1;
        wr(8'd0, 1'b0);
        tick();
        check("R6 load", int'(count), 0);
        for (int i = 0; i < 65535; i++) tick();
        check("R6 before", int'(count), 1);
        check("R6 out low", int'(out), 0);
        tick();
        check("R6 count", int'(count), 0);
        check("R6 out", int'(out), 1);

        // R7 two-byte write halts in interrupt mode
        do_reset(1'b0);
        gate = 1'b1;
        wr(8'd20, 1'b0);
        tick(); tick();
        two_byte = 1'b1;
        wr(8'h34, 1'b0);
        check("R7 last step", int'(count), 18);
        tick(); tick(); tick();
        check("R7 halted", int'(count), 18);
        wr(8'h01, 1'b1);
        check("R7 still", int'(count), 18);
        tick();
        check("R7 loaded", int'(count), 16'h0134);
        tick();
        check("R7 resumed", int'(count), 16'h0133);

        // R4 R7 low byte write pulls OUT low after terminal count
        do_reset(1'b0);
        gate = 1'b1;
        wr(8'd1, 1'b0);
        tick(); tick();
        check("R4 high", int'(out), 1);
        two_byte = 1'b1;
        wr(8'h05, 1'b0);
        check("R7 out low", int'(out), 0);

        // R8 two-byte write in strobe mode keeps counting
        do_reset(1'b1);
        gate = 1'b1;
        wr(8'd20, 1'b0);
        tick(); tick();
        two_byte = 1'b1;
        wr(8'h05, 1'b0);
        check("R8 step", int'(count), 18);
        tick(); tick();
        check("R8 running", int'(count), 16);
        wr(8'h00, 1'b1);
        check("R8 before load", int'(count), 15);
        tick();
        check("R8 loaded", int'(count), 5);
        tick();
        check("R8 next", int'(count), 4);

        // R9 mode change re-initialises
        do_reset(1'b0);
        gate = 1'b1;
        two_byte = 1'b0;
        wr(8'd9, 1'b0);
        tick(); tick();
        check("R9 pre", int'(count), 8);
        mode = 1'b1;
        tick();
        check("R9 out strobe idle", int'(out), 1);
        check("R9 count held", int'(count), 8);
        tick();
        check("R9 no count", int'(count), 8);
        mode = 1'b0;
        tick();
        check("R9 out irq idle", int'(out), 0);
        wr(8'd3, 1'b0);
        tick();
        check("R9 reload", int'(count), 3);
        mode = 1'b1;
        wr(8'd7, 1'b0);
        tick();
        check("R9 load dropped", int'(count), 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule